// File: doc/BRIEF.md
# Register-Cached Histogram Accumulator

This block builds a histogram of an incoming stream of values. Each value selects one of 64 bins, and the block adds one to that bin's count. The counts are kept in a block RAM whose reads take several cycles. The update is a read-modify-write, and a plain RAM would stall the stream until each write had landed. To avoid this, a short shift register of recently written (bin, count) pairs sits in front of the RAM. Every lookup checks this register before it uses RAM data. A count moves into the RAM only when it drops off the far end of the shift register.

A run starts with a pulse on `start`. The block then zeroes every bin and empties the cache while `in_ready` is held low. After that it accepts values over a valid/ready stream. The value flagged as last ends the run: the block waits for the pipeline to empty, writes the remaining cached counts back to RAM, and then raises `done`. While `done` is high, the bins can be read out through a pipelined port at one address per clock.

The RAM read latency and the cache depth are both parameters. A depth of zero, or any depth below the read latency, still gives exact counts. In that case the block holds `in_ready` low only while an update to the same bin is still in flight in a part of the pipeline that neither the cache nor forwarding can cover.

Top module: `hist_cache_acc`

## Requirements
- R1: When the cache depth is at least the RAM read latency, the block accepts one input on every cycle of a run, so a stream of N values held valid continuously is fully accepted in N consecutive cycles.
- R2: The bin of an input is its low 6 bits (`in_data[5:0]`). All higher bits are ignored, and each accepted input adds exactly one to the count of that bin.
- R3: Counts are exact for every cache depth, including zero. With a depth below the read latency, `in_ready` may drop for a few cycles between inputs that hit the same bin.
- R4: Inputs that repeat a bin back to back, or at any distance up to the pipeline length, each see the newest count of that bin. The update written on the current cycle takes priority over all cached entries, and newer cached entries take priority over older ones.
- R5: Counts are `CNT_W` bits wide and wrap to zero on overflow, modulo 2^CNT_W.
- R6: A `start` pulse zeroes all 64 bins and drops any earlier cache contents. `in_ready` and `done` are low on the cycle after `start`, and `in_ready` stays low for exactly 64 cycles before the first input can be accepted.
- R7: `done` rises exactly RD_LAT + CACHE_DEPTH + 1 cycles after the clock edge that accepts the last input. It then stays high until the next `start`.
- R8: While `done` is high, a `rd_req` with `rd_addr` returns that bin's final count on `rd_data` with `rd_valid` high, RD_LAT cycles later. A new request may be issued on every cycle.
- R9: A `rd_req` made while `done` is low is ignored: no `rd_valid` ever follows it.
- R10: After reset, `in_ready` and `done` are both low until a `start` pulse is given. `in_ready` is low whenever `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse: clear all bins and begin a new run |
| in_valid | input | 1 | Input value present |
| in_ready | output | 1 | Block can take the input this cycle |
| in_data | input | DATA_W | Input value; low BIN_W bits pick the bin |
| in_last | input | 1 | Marks the final input of the run |
| done | output | 1 | Run finished and all counts are in RAM |
| rd_req | input | 1 | Readout request, honoured only while done |
| rd_addr | input | BIN_W | Bin to read out |
| rd_valid | output | 1 | Readout data valid |
| rd_data | output | CNT_W | Count of the requested bin |

## Verification
The bench builds two instances side by side. The first uses the default read latency of 3 with a cache depth of 4 and 32-bit counts, so every hazard is covered by the cache and any loss of full-rate acceptance shows up as a lost cycle. The second has no cache and 4-bit counts at the same latency. This brings the stall-and-forward path and counter wrap within reach after a few dozen hits on one bin. Both instances see directed runs of one bin, alternating bins at distances of one to four, and bins picked through different high bits, mixed with seeded random traffic. Two runs are made back to back, so that clearing by `start` is also exercised.

// File: rtl/hist_pkg.sv
// Package: shared types for the cached histogram accumulator.
// Assumes: nothing beyond IEEE 1800-2017.
package hist_pkg;

    // Controller phases of one histogram run
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_RUN,
        ST_FLUSH,
        ST_DONE
    } hist_state_e;

endpackage

// File: rtl/hist_ram.sv
// Module: simple dual-port count store with a fixed multi-cycle read path.
// Write lands at the clock edge. A read address sampled at an edge returns
// data LAT cycles later. A read and a write to the same address at the same
// edge return the old data.
// Assumes: LAT >= 1; contents are not reset (the controller clears them).
module hist_ram #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int LAT    = 3
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem  [WORDS];
    logic [DATA_W-1:0] pipe [LAT];

    // Write port
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Read port: array access followed by LAT-1 output stages
    always_ff @(posedge clk) begin
        pipe[0] <= mem[rd_addr];
        for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
    end

    assign rd_data = pipe[LAT-1];

endmodule

// File: rtl/hist_fwd_cache.sv
// Module: shift-register write cache of (bin, count) pairs.
// Every cycle the register shifts by one. The head takes the update of this
// cycle (or an empty slot), and the entry leaving the tail is handed out for
// write-back. Two independent lookups return the newest matching entry.
// Assumes: DEPTH >= 1 (depth zero is handled by the parent without this module).
module hist_fwd_cache #(
    parameter int DEPTH = 4,
    parameter int BIN_W = 6,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv,
    input  logic             push_vld,
    input  logic [BIN_W-1:0] push_bin,
    input  logic [CNT_W-1:0] push_cnt,
    input  logic [BIN_W-1:0] qa_bin,
    output logic             qa_hit,
    output logic [CNT_W-1:0] qa_cnt,
    input  logic [BIN_W-1:0] qb_bin,
    output logic             qb_hit,
    output logic [CNT_W-1:0] qb_cnt,
    output logic             tail_vld,
    output logic [BIN_W-1:0] tail_bin,
    output logic [CNT_W-1:0] tail_cnt
);
    logic             ent_vld [DEPTH];
    logic [BIN_W-1:0] ent_bin [DEPTH];
    logic [CNT_W-1:0] ent_cnt [DEPTH];

    // Valid bits: cleared by reset or invalidate, otherwise shifted
    always_ff @(posedge clk) begin
        if (!rst_n || inv) begin
            for (int i = 0; i < DEPTH; i++) ent_vld[i] <= 1'b0;
        end else begin
            ent_vld[0] <= push_vld;
            for (int i = 1; i < DEPTH; i++) ent_vld[i] <= ent_vld[i-1];
        end
    end

    // Payload: shifted every cycle, meaningful only where valid
    always_ff @(posedge clk) begin
        ent_bin[0] <= push_bin;
        ent_cnt[0] <= push_cnt;
        for (int i = 1; i < DEPTH; i++) begin
            ent_bin[i] <= ent_bin[i-1];
            ent_cnt[i] <= ent_cnt[i-1];
        end
    end

    // Lookups: scan oldest to newest so the newest match wins
    always_comb begin
        qa_hit = 1'b0;
        qa_cnt = '0;
        qb_hit = 1'b0;
        qb_cnt = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (ent_vld[i] && ent_bin[i] == qa_bin) begin
                qa_hit = 1'b1;
                qa_cnt = ent_cnt[i];
            end
            if (ent_vld[i] && ent_bin[i] == qb_bin) begin
                qb_hit = 1'b1;
                qb_cnt = ent_cnt[i];
            end
        end
    end

    assign tail_vld = ent_vld[DEPTH-1];
    assign tail_bin = ent_bin[DEPTH-1];
    assign tail_cnt = ent_cnt[DEPTH-1];

endmodule

// File: rtl/hist_cache_acc.sv
// Module: histogram accumulator with a register cache in front of a
// multi-cycle RAM.
// An accepted input issues a RAM read and looks up the cache (issue point).
// RD_LAT cycles later the count is chosen (consume point): a cache hit at
// consume, else the value captured at issue, else the RAM data. One is then
// added, and the result is pushed into the cache head. Entries leaving the
// cache tail are written to RAM. With CACHE_DEPTH >= RD_LAT there are no
// stalls. Below that, in_ready drops for the uncovered window.
// Assumes: DATA_W > BIN_W, RD_LAT >= 1, start is a single-cycle pulse.
module hist_cache_acc
    import hist_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int BIN_W       = 6,
    parameter int CNT_W       = 32,
    parameter int RD_LAT      = 3,
    parameter int CACHE_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              done,
    input  logic              rd_req,
    input  logic [BIN_W-1:0]  rd_addr,
    output logic              rd_valid,
    output logic [CNT_W-1:0]  rd_data
);
    localparam int NBINS     = 1 << BIN_W;
    localparam int FLUSH_CYC = RD_LAT + CACHE_DEPTH;
    localparam int FL_W      = $clog2(FLUSH_CYC + 1);

    hist_state_e      state;
    logic [BIN_W-1:0] clr_cnt;
    logic [FL_W-1:0]  fl_cnt;

    logic [BIN_W-1:0] in_bin;
    logic             unused_hi;
    logic             stall, fire;

    logic             p_vld [RD_LAT];
    logic [BIN_W-1:0] p_bin [RD_LAT];
    logic             p_hit [RD_LAT];
    logic [CNT_W-1:0] p_cnt [RD_LAT];
    logic             rv_q  [RD_LAT];

    logic             cons_vld;
    logic [BIN_W-1:0] cons_bin;
    logic [CNT_W-1:0] base_cnt, new_cnt;
    logic             fwd_hit, iss_hit;
    logic [CNT_W-1:0] iss_cnt;

    logic             qa_hit, qb_hit;
    logic [CNT_W-1:0] qa_cnt, qb_cnt;
    logic             tail_vld;
    logic [BIN_W-1:0] tail_bin;
    logic [CNT_W-1:0] tail_cnt;

    logic             ram_we;
    logic [BIN_W-1:0] ram_waddr, ram_raddr;
    logic [CNT_W-1:0] ram_wdata, ram_rdata;

    // Bin selection from the low input bits; the rest is ignored
    assign in_bin    = in_data[BIN_W-1:0];
    assign unused_hi = ^in_data[DATA_W-1:BIN_W];

    // Hazard: same bin in flight where neither cache nor forwarding reaches
    always_comb begin
        stall = 1'b0;
        for (int k = 0; k < RD_LAT; k++) begin
            if (k >= CACHE_DEPTH && k <= RD_LAT - 2 && p_vld[k] && p_bin[k] == in_bin)
                stall = 1'b1;
        end
    end

    assign in_ready = (state == ST_RUN) && !stall;
    assign fire     = in_valid && in_ready;

    // Run controller: clear sweep, accept, flush, done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            clr_cnt <= '0;
            fl_cnt  <= '0;
        end else if (start) begin
            state   <= ST_CLEAR;
            clr_cnt <= '0;
        end else begin
            case (state)
                ST_CLEAR: begin
                    clr_cnt <= clr_cnt + 1'b1;
                    if (clr_cnt == BIN_W'(NBINS - 1)) state <= ST_RUN;
                end
                ST_RUN: begin
                    if (fire && in_last) begin
                        state  <= ST_FLUSH;
                        fl_cnt <= '0;
                    end
                end
                ST_FLUSH: begin
                    fl_cnt <= fl_cnt + 1'b1;
                    if (fl_cnt == FL_W'(FLUSH_CYC - 1)) state <= ST_DONE;
                end
                default: ;
            endcase
        end
    end

    // Consume point: pick the newest count and add one
    assign cons_vld = p_vld[RD_LAT-1];
    assign cons_bin = p_bin[RD_LAT-1];
    assign base_cnt = qb_hit ? qb_cnt : (p_hit[RD_LAT-1] ? p_cnt[RD_LAT-1] : ram_rdata);
    assign new_cnt  = base_cnt + 1'b1;

    // Issue point: this cycle's update outranks every cached entry
    assign fwd_hit = cons_vld && (cons_bin == in_bin);
    assign iss_hit = fwd_hit || qa_hit;
    assign iss_cnt = fwd_hit ? new_cnt : qa_cnt;

    // Update pipeline valid bits, aligned with the RAM read latency
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            for (int k = 0; k < RD_LAT; k++) p_vld[k] <= 1'b0;
        end else begin
            p_vld[0] <= fire;
            for (int k = 1; k < RD_LAT; k++) p_vld[k] <= p_vld[k-1];
        end
    end

    // Update pipeline payload: bin and the value captured at issue
    always_ff @(posedge clk) begin
        p_bin[0] <= in_bin;
        p_hit[0] <= iss_hit;
        p_cnt[0] <= iss_cnt;
        for (int k = 1; k < RD_LAT; k++) begin
            p_bin[k] <= p_bin[k-1];
            p_hit[k] <= p_hit[k-1];
            p_cnt[k] <= p_cnt[k-1];
        end
    end

    // Readout valid tracker, honoured only once the run is done
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            for (int k = 0; k < RD_LAT; k++) rv_q[k] <= 1'b0;
        end else begin
            rv_q[0] <= rd_req && (state == ST_DONE);
            for (int k = 1; k < RD_LAT; k++) rv_q[k] <= rv_q[k-1];
        end
    end

    // Cache variant chosen by depth
    if (CACHE_DEPTH == 0) begin : g_nocache
        assign qa_hit   = 1'b0;
        assign qa_cnt   = '0;
        assign qb_hit   = 1'b0;
        assign qb_cnt   = '0;
        assign tail_vld = cons_vld;
        assign tail_bin = cons_bin;
        assign tail_cnt = new_cnt;
    end else begin : g_cache
        hist_fwd_cache #(
            .DEPTH (CACHE_DEPTH),
            .BIN_W (BIN_W),
            .CNT_W (CNT_W)
        ) u_cache (
            .clk      (clk),
            .rst_n    (rst_n),
            .inv      (state == ST_CLEAR),
            .push_vld (cons_vld),
            .push_bin (cons_bin),
            .push_cnt (new_cnt),
            .qa_bin   (in_bin),
            .qa_hit   (qa_hit),
            .qa_cnt   (qa_cnt),
            .qb_bin   (cons_bin),
            .qb_hit   (qb_hit),
            .qb_cnt   (qb_cnt),
            .tail_vld (tail_vld),
            .tail_bin (tail_bin),
            .tail_cnt (tail_cnt)
        );
    end

    // RAM port muxing: clear sweep or tail write-back; run or readout read
    assign ram_we    = (state == ST_CLEAR) || tail_vld;
    assign ram_waddr = (state == ST_CLEAR) ? clr_cnt : tail_bin;
    assign ram_wdata = (state == ST_CLEAR) ? '0 : tail_cnt;
    assign ram_raddr = (state == ST_DONE) ? rd_addr : in_bin;

    hist_ram #(
        .ADDR_W (BIN_W),
        .DATA_W (CNT_W),
        .LAT    (RD_LAT)
    ) u_ram (
        .clk     (clk),
        .wr_en   (ram_we),
        .wr_addr (ram_waddr),
        .wr_data (ram_wdata),
        .rd_addr (ram_raddr),
        .rd_data (ram_rdata)
    );

    assign done     = (state == ST_DONE);
    assign rd_valid = rv_q[RD_LAT-1];
    assign rd_data  = ram_rdata;

endmodule

// File: rtl/hist_cache_acc_chk.sv
// Module: protocol checker for hist_cache_acc, bound to every instance.
// Assumes: observes ports and the controller phase only.
module hist_cache_acc_chk
    import hist_pkg::*;
#(
    parameter int RD_LAT      = 3,
    parameter int CACHE_DEPTH = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        in_ready,
    input logic        done,
    input logic        rd_valid,
    input hist_state_e state
);
    // R1: full rate while running when the cache covers the read latency
    if (CACHE_DEPTH >= RD_LAT) begin : g_full_rate
        p_full_rate_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (state == ST_RUN) |-> in_ready);
    end

    // R6: a start pulse blocks input and clears done on the next cycle
    p_start_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!in_ready && !done));

    // R7: done is held until the next start
    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R8: readout data only follows a cycle in which the run was done
    p_rd_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(done));

    // R9: no readout data outside the done phase
    p_rd_only_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> done);

    // R10: input is never accepted once the run is done
    p_done_no_input_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !in_ready);

endmodule

bind hist_cache_acc hist_cache_acc_chk #(
    .RD_LAT      (RD_LAT),
    .CACHE_DEPTH (CACHE_DEPTH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .in_ready (in_ready),
    .done     (done),
    .rd_valid (rd_valid),
    .state    (state)
);

// File: tb/hist_cache_acc_tb_top.sv
// Bench: two instances (cache depth 4 / 32-bit counts, and no cache / 4-bit
// counts) fed the same value sequence, each with its own handshake.
module hist_cache_acc_tb_top;
    localparam int LAT  = 3;
    localparam int DA   = 4;
    localparam int DB   = 0;
    localparam int NMAX = 400;
    localparam int NB   = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        start = 1'b0;
    logic        rd_req = 1'b0;
    logic [5:0]  rd_addr = '0;

    logic        a_valid = 1'b0, a_last = 1'b0;
    logic [15:0] a_data = '0;
    logic        a_ready, a_done, a_rvld;
    logic [31:0] a_rdata;

    logic        b_valid = 1'b0, b_last = 1'b0;
    logic [15:0] b_data = '0;
    logic        b_ready, b_done, b_rvld;
    logic [3:0]  b_rdata;

    logic [15:0] stim [NMAX];
    int n_chk = 0, n_fail = 0;
    int a_last_cyc, b_last_cyc, a_done_cyc, b_done_cyc;

    hist_cache_acc #(.RD_LAT(LAT), .CACHE_DEPTH(DA)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .in_valid(a_valid), .in_ready(a_ready), .in_data(a_data), .in_last(a_last),
        .done(a_done), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(a_rvld), .rd_data(a_rdata)
    );

    hist_cache_acc #(.CNT_W(4), .RD_LAT(LAT), .CACHE_DEPTH(DB)) dut_nc (
        .clk(clk), .rst_n(rst_n), .start(start),
        .in_valid(b_valid), .in_ready(b_ready), .in_data(b_data), .in_last(b_last),
        .done(b_done), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(b_rvld), .rd_data(b_rdata)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference count of a bin over the first n stimulus values
    function automatic int unsigned ref_count(input int bin, input int n);
        int unsigned c = 0;
        for (int i = 0; i < n; i++) if (int'(stim[i][5:0]) == bin) c++;
        return c;
    endfunction

    // Start a run; check the 64-cycle clear window and ignored readout
    task automatic do_start();
        int lows = 0, rv_seen = 0;
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start  = 1'b0;
        rd_req = 1'b1;
        chk(!a_done && !b_done, "R6 done low after start", a_done, 0);
        for (int i = 1; i <= 64; i++) begin
            if (i > 1) @(negedge clk);
            if (!a_ready && !b_ready) lows++;
            if (a_rvld || b_rvld) rv_seen++;
        end
        chk(lows == 64, "R6 ready low during clear", lows, 64);
        @(negedge clk);
        rd_req = 1'b0;
        chk(a_ready && b_ready, "R6 ready after clear", {a_ready, b_ready}, 3);
        chk(rv_seen == 0, "R9 readout ignored before done", rv_seen, 0);
    endtask

    // Feed n values to both instances, record last-accept and done cycles
    task automatic run_stream(input int n);
        int ai = 0, bi = 0, cyc = 0;
        bit a_seen = 0, b_seen = 0, af, bf;
        while (!(a_seen && b_seen) && cyc < 5000) begin
            @(negedge clk);
            a_valid = (ai < n);
            a_data  = (ai < n) ? stim[ai] : '0;
            a_last  = (ai == n - 1);
            b_valid = (bi < n);
            b_data  = (bi < n) ? stim[bi] : '0;
            b_last  = (bi == n - 1);
            #1;
            if (!a_seen && a_done) begin a_seen = 1; a_done_cyc = cyc; end
            if (!b_seen && b_done) begin b_seen = 1; b_done_cyc = cyc; end
            af = a_valid && a_ready;
            bf = b_valid && b_ready;
            if (af && a_last) a_last_cyc = cyc;
            if (bf && b_last) b_last_cyc = cyc;
            @(posedge clk);
            if (af) ai++;
            if (bf) bi++;
            cyc++;
        end
        @(negedge clk);
        a_valid = 1'b0;
        b_valid = 1'b0;
        a_last  = 1'b0;
        b_last  = 1'b0;
    endtask

    // Pipelined readout of all bins, compared with the reference counts
    task automatic readout(input int n, input string tag);
        for (int i = 0; i < NB + LAT; i++) begin
            @(negedge clk);
            if (i >= LAT) begin
                int unsigned e = ref_count(i - LAT, n);
                chk(a_rvld && b_rvld, {"R8 readout valid ", tag}, {a_rvld, b_rvld}, 3);
                chk(a_rdata == e, {"R2 R4 bin count ", tag}, a_rdata, e);
                chk(b_rdata == 4'(e), {"R3 R5 wrapped count no cache ", tag}, b_rdata, 4'(e));
            end
            rd_req  = (i < NB);
            rd_addr = 6'(i);
        end
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    initial begin : main
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!a_ready && !a_done && !b_ready && !b_done, "R10 reset state",
            {a_ready, a_done, b_ready, b_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!a_ready && !a_done, "R10 idle before start", {a_ready, a_done}, 0);

        // Pass 1: directed hazards then biased random traffic
        for (int i = 0; i < NMAX; i++) begin
            if (i < 10)      stim[i] = 16'd5;
            else if (i < 20) stim[i] = (i % 2 == 1) ? 16'd9 : 16'd10 + 16'd64 * 16'(i);
            else if (i < 30) stim[i] = 16'(20 + i % 3);
            else if (i < 40) stim[i] = 16'(40 + i % 4) | 16'h8000;
            else if ($urandom % 2 == 0) stim[i] = 16'($urandom % 4);
            else stim[i] = 16'($urandom);
        end
        do_start();
        run_stream(NMAX);
        chk(a_last_cyc == NMAX - 1, "R1 one input per cycle", a_last_cyc, NMAX - 1);
        chk(b_last_cyc > NMAX - 1, "R3 no-cache instance throttles", b_last_cyc, NMAX);
        chk(a_done_cyc - a_last_cyc == LAT + DA + 1, "R7 done latency cached",
            a_done_cyc - a_last_cyc, LAT + DA + 1);
        chk(b_done_cyc - b_last_cyc == LAT + DB + 1, "R7 done latency no cache",
            b_done_cyc - b_last_cyc, LAT + DB + 1);
        repeat (5) @(negedge clk);
        chk(a_done && b_done && !a_ready, "R7 R10 done held", {a_done, b_done, a_ready}, 6);
        readout(NMAX, "pass1");

        // Pass 2: fresh run must not carry earlier counts
        for (int i = 0; i < 150; i++)
            stim[i] = 16'($urandom % 64) | 16'(($urandom % 1024) << 6);
        do_start();
        run_stream(150);
        chk(a_last_cyc == 149, "R1 full rate second run", a_last_cyc, 149);
        readout(150, "pass2 R6 cleared");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule